// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of translation tables from memory. A requester presents a virtual address while the walker is idle. The walker then fetches a directory entry chosen by the top ten address bits. If that entry is marked valid, it fetches a page entry from the table the directory entry names, chosen by the next ten address bits. It answers with either the physical address or an abort.

A table-base input gives the location of the directory. Loading a different value into it selects a whole new virtual address space. The walker captures that value when it accepts a request. Memory is reached through a single read port with a request/ready handshake. Only one walk runs at a time, and a busy output tells the requester when new requests are refused.

Top module: `pt_walker`

## Requirements
- R1: While reset is applied and after it is released, busy_o, done_o and mem_req_o are low until a request is accepted.
- R2: A request is accepted only on a clock edge where req_valid_i is high and busy_o is low. busy_o is high from the next cycle until the cycle after done_o.
- R3: The first read of a walk uses address {tbase_i[31:12], vaddr[31:22], 2'b00}.
- R4: When the directory entry is valid, the second read uses address {dir_entry[31:12], vaddr[21:12], 2'b00}.
- R5: mem_req_o stays high with mem_addr_o unchanged until mem_ready_i is sampled high.
- R6: Bit 0 of an entry is its valid bit. A directory entry with bit 0 clear ends the walk with an abort after exactly one read, whatever its upper bits hold.
- R7: A page entry with bit 0 clear ends the walk with an abort after two reads.
- R8: A walk whose two entries are both valid sets done_o high for exactly one cycle, with paddr_o = {page_entry[31:12], vaddr[11:0]} and abort_o low.
- R9: On an abort, done_o is high for one cycle with abort_o high and paddr_o equal to zero.
- R10: The table base is captured when a request is accepted. Changing tbase_i during a walk does not affect that walk. Changing it between walks changes the translation of the same virtual address.
- R11: req_valid_i pulses while busy_o is high are ignored and produce no result.
- R12: Addresses at both index extremes (all zeros and all ones) translate correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tbase_i | input | 32 | Directory base address (bits 31:12 used) |
| req_valid_i | input | 1 | Translation request strobe |
| req_vaddr_i | input | 32 | Virtual address to translate |
| busy_o | output | 1 | A walk is in progress; requests are refused |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| abort_o | output | 1 | Result is an abort (no mapping) |
| paddr_o | output | 32 | Physical address, zero on abort |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_ready_i | input | 1 | Memory has returned data this cycle |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
A wrong captured virtual address or table base shows up at mem_addr_o on the first read. That is one cycle after acceptance, and the read address is compared against the expected value there. A corrupt directory-frame register shows up at the second read address. A stuck or skipped state shows up as a wrong number of reads, or as done_o arriving with no pending result. Either is caught at the cycle of the pulse. Memory latency is varied between zero and several cycles, so that address hold and handshake errors are exercised.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_DIR  = 2'd1,
    PW_TBL  = 2'd2,
    PW_RESP = 2'd3
  } pw_state_e;

  // log2 of the entry size in bytes
  localparam int unsigned ENTRY_LG = 2;
endpackage

// File: rtl/pw_rst_sync.sv
module pw_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_valid_i,
  input  logic      mem_ready_i,
  input  logic      entry_valid_i,
  output pw_state_e state_o,
  output logic      accept_o,
  output logic      dir_load_o,
  output logic      res_load_o
);
  pw_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    accept_o   = 1'b0;
    dir_load_o = 1'b0;
    res_load_o = 1'b0;
    case (state_q)
      PW_IDLE: begin
        if (req_valid_i) begin
          accept_o = 1'b1;
          state_d  = PW_DIR;
        end
      end
      PW_DIR: begin
        if (mem_ready_i) begin
          if (entry_valid_i) begin
            dir_load_o = 1'b1;
            state_d    = PW_TBL;
          end else begin
            res_load_o = 1'b1;
            state_d    = PW_RESP;
          end
        end
      end
      PW_TBL: begin
        if (mem_ready_i) begin
          res_load_o = 1'b1;
          state_d    = PW_RESP;
        end
      end
      PW_RESP: state_d = PW_IDLE;
      default: state_d = PW_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PW_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R8: the result state lasts one cycle
  assert_resp_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PW_RESP |=> state_q == PW_IDLE);

  // R5: a read in flight keeps its state until ready
  assert_wait_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == PW_DIR || state_q == PW_TBL) && !mem_ready_i) |=> state_q == $past(state_q));

  // R6: an invalid directory entry goes straight to the result
  assert_dir_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PW_DIR && mem_ready_i && !entry_valid_i) |=> state_q == PW_RESP);
endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              sel_tbl_i,
  input  logic [ADDR_W-OFF_W-1:0] base_frame_i,
  input  logic [ADDR_W-OFF_W-1:0] tbl_frame_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  output logic [ADDR_W-1:0] addr_o
);
  import pw_pkg::*;

  localparam int unsigned FRAME_W = ADDR_W - OFF_W;
  localparam int unsigned IDX_W   = OFF_W - ENTRY_LG;
  localparam int unsigned TOP_W   = ADDR_W - OFF_W - IDX_W;

  logic [TOP_W-1:0]  dir_idx;
  logic [IDX_W-1:0]  tbl_idx;
  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] tbl_addr;

  assign dir_idx  = vaddr_i[ADDR_W-1 -: TOP_W];
  assign tbl_idx  = vaddr_i[OFF_W +: IDX_W];
  assign tbl_addr = {tbl_frame_i, tbl_idx, {ENTRY_LG{1'b0}}};

  generate
    if (TOP_W == IDX_W) begin : g_dir_concat
      assign dir_addr = {base_frame_i, dir_idx, {ENTRY_LG{1'b0}}};
    end else begin : g_dir_add
      logic [ADDR_W-1:0] base_addr;
      logic [ADDR_W-1:0] dir_off;
      assign base_addr = {base_frame_i, {OFF_W{1'b0}}};
      assign dir_off   = {{(ADDR_W-TOP_W-ENTRY_LG){1'b0}}, dir_idx, {ENTRY_LG{1'b0}}};
      assign dir_addr  = base_addr + dir_off;
    end
  endgenerate

  assign addr_o = sel_tbl_i ? tbl_addr : dir_addr;

  initial begin
    if (FRAME_W + OFF_W != ADDR_W) $display("pw_addr_gen: width mismatch");
  end
endmodule

// File: rtl/pw_result.sv
module pw_result #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              from_tbl_i,
  input  logic              entry_valid_i,
  input  logic [ADDR_W-OFF_W-1:0] frame_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              abort_o
);
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic              abort_q, abort_d;
  logic              hit;

  assign hit = from_tbl_i && entry_valid_i;

  always_comb begin
    paddr_d = paddr_q;
    abort_d = abort_q;
    if (load_i) begin
      paddr_d = hit ? {frame_i, offset_i} : '0;
      abort_d = !hit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paddr_q <= '0;
      abort_q <= 1'b0;
    end else begin
      paddr_q <= paddr_d;
      abort_q <= abort_d;
    end
  end

  assign paddr_o = paddr_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic [ADDR_W-1:0] tbase_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              abort_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [ADDR_W-1:0] mem_rdata_i
);
  import pw_pkg::*;

  localparam int unsigned FRAME_W = ADDR_W - OFF_W;

  logic              rst_n;
  pw_state_e         state;
  logic              accept, dir_load, res_load;
  logic              entry_valid;
  logic [FRAME_W-1:0] entry_frame;
  logic [ADDR_W-1:0] vaddr_q, vaddr_d;
  logic [FRAME_W-1:0] base_frame_q, base_frame_d;
  logic [FRAME_W-1:0] tbl_frame_q, tbl_frame_d;
  logic              res_abort;
  logic [ADDR_W-1:0] res_paddr;
  logic              pw_unused_bits;

  assign entry_valid    = mem_rdata_i[0];
  assign entry_frame    = mem_rdata_i[ADDR_W-1 -: FRAME_W];
  assign pw_unused_bits = ^{mem_rdata_i[OFF_W-1:1], tbase_i[OFF_W-1:0]};

  pw_rst_sync i_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_n)
  );

  pw_ctrl i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .req_valid_i   (req_valid_i),
    .mem_ready_i   (mem_ready_i),
    .entry_valid_i (entry_valid),
    .state_o       (state),
    .accept_o      (accept),
    .dir_load_o    (dir_load),
    .res_load_o    (res_load)
  );

  // capture registers, clock enables written out
  always_comb begin
    vaddr_d      = accept   ? req_vaddr_i : vaddr_q;
    base_frame_d = accept   ? tbase_i[ADDR_W-1 -: FRAME_W] : base_frame_q;
    tbl_frame_d  = dir_load ? entry_frame : tbl_frame_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q      <= '0;
      base_frame_q <= '0;
      tbl_frame_q  <= '0;
    end else begin
      vaddr_q      <= vaddr_d;
      base_frame_q <= base_frame_d;
      tbl_frame_q  <= tbl_frame_d;
    end
  end

  pw_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_addr_gen (
    .sel_tbl_i    (state == PW_TBL),
    .base_frame_i (base_frame_q),
    .tbl_frame_i  (tbl_frame_q),
    .vaddr_i      (vaddr_q),
    .addr_o       (mem_addr_o)
  );

  pw_result #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_result (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .load_i        (res_load),
    .from_tbl_i    (state == PW_TBL),
    .entry_valid_i (entry_valid),
    .frame_i       (entry_frame),
    .offset_i      (vaddr_q[OFF_W-1:0]),
    .paddr_o       (res_paddr),
    .abort_o       (res_abort)
  );

  assign busy_o    = (state != PW_IDLE);
  assign done_o    = (state == PW_RESP);
  assign mem_req_o = (state == PW_DIR) || (state == PW_TBL);
  assign abort_o   = done_o && res_abort;
  assign paddr_o   = done_o ? res_paddr : '0;

  // R5: address held until ready
  assert_addr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R9: abort carries a zero address
  assert_abort_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    abort_o |-> (done_o && paddr_o == '0));

  // R2: no memory traffic while idle
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);

  // R10: captured base does not move during a walk
  assert_base_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy_o && !done_o) |=> $stable(base_frame_q));
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/100ps
module test_pt_walker;
  logic        clk = 1'b0;
  logic        arst_n;
  logic [31:0] tbase;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        busy, done, abort_w, mem_req, mem_ready;
  logic [31:0] paddr, mem_addr, mem_rdata;

  always #2.5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk_i(clk), .arst_ni(arst_n), .tbase_i(tbase),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .busy_o(busy), .done_o(done), .abort_o(abort_w), .paddr_o(paddr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
  );

  typedef struct packed {
    logic [31:0] pa;
    logic        ab;
    logic [1:0]  nrd;
    logic [31:0] a0;
    logic [31:0] a1;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mem [logic [31:0]];
  int          n_chk = 0, n_fail = 0;
  int          lat = 0;
  int          waitcnt = 0;
  int          rdcnt = 0;
  logic [31:0] rdaddr [2];
  logic        prev_req = 1'b0, prev_rdy = 1'b0;
  logic [31:0] prev_addr = '0;
  logic        run = 1'b0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor and memory model
  always @(negedge clk) begin
    if (run) begin
      if (done) begin
        if (sb.size() == 0) chk(1'b0, "R11 result with no request", paddr, 32'h0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(paddr == e.pa, "R8/R9 paddr", paddr, e.pa);
          chk(abort_w == e.ab, "R6/R7/R9 abort", {31'b0, abort_w}, {31'b0, e.ab});
          chk(rdcnt == int'(e.nrd), "R6/R7 read count", rdcnt, {30'b0, e.nrd});
          chk(rdaddr[0] == e.a0, "R3 first read address", rdaddr[0], e.a0);
          if (e.nrd == 2'd2) chk(rdaddr[1] == e.a1, "R4 second read address", rdaddr[1], e.a1);
        end
        rdcnt = 0;
      end
      // R5 hold check
      if (prev_req && !prev_rdy)
        chk(mem_req && mem_addr == prev_addr, "R5 address hold", mem_addr, prev_addr);
      prev_req  = mem_req;
      prev_addr = mem_addr;
      if (mem_ready) waitcnt = 0;
      mem_ready = 1'b0;
      mem_rdata = '0;
      if (mem_req) begin
        if (waitcnt >= lat) begin
          if (rdcnt < 2) rdaddr[rdcnt] = mem_addr;
          rdcnt++;
          mem_ready = 1'b1;
          mem_rdata = rd(mem_addr);
        end else waitcnt++;
      end
      prev_rdy = mem_ready;
    end
  end

  function automatic exp_t model(input logic [31:0] base, input logic [31:0] va);
    exp_t e;
    logic [31:0] de, pe;
    e.a0 = {base[31:12], va[31:22], 2'b00};
    de   = rd(e.a0);
    e.a1 = {de[31:12], va[21:12], 2'b00};
    if (!de[0]) begin
      e.pa = 0; e.ab = 1'b1; e.nrd = 2'd1;
    end else begin
      pe = rd(e.a1);
      e.nrd = 2'd2;
      e.ab  = !pe[0];
      e.pa  = pe[0] ? {pe[31:12], va[11:0]} : 32'h0;
    end
    return e;
  endfunction

  task automatic do_req(input logic [31:0] va);
    while (busy) @(negedge clk);
    sb.push_back(model(tbase, va));
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", {31'b0, busy}, 32'h1);
  endtask

  task automatic drain;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    finish_up();
  end

  initial begin
    arst_n = 1'b0; tbase = 32'h0001_0000; req_valid = 1'b0; req_vaddr = '0;
    mem_ready = 1'b0; mem_rdata = '0;
    // space A at 0x10000
    mem[32'h0001_0004] = 32'h0002_0001;
    mem[32'h0002_000C] = 32'h1234_5001;
    mem[32'h0001_0FFC] = 32'h0003_0001;
    mem[32'h0003_0FFC] = 32'hABCD_E001;
    mem[32'h0001_0000] = 32'h0004_0001;
    mem[32'h0004_0000] = 32'h0000_1001;
    mem[32'h0001_000C] = 32'h0005_0000;
    mem[32'h0002_0010] = 32'h5555_5000;
    // space B at 0x80000
    mem[32'h0008_0004] = 32'h0009_0001;
    mem[32'h0009_000C] = 32'h7777_7001;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 outputs during reset", {busy, done, mem_req}, 32'h0);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 outputs after reset", {busy, done, mem_req}, 32'h0);
    run = 1'b1;

    for (int l = 0; l < 3; l++) begin
      lat = (l == 2) ? 3 : l;
      do_req(32'h0040_3ABC);   // R8 hit
      do_req(32'h0080_0123);   // R6 absent directory entry
      do_req(32'h0040_4FFF);   // R7 invalid page entry
      do_req(32'hFFFF_FFFF);   // R12 top corner
      do_req(32'h0000_0000);   // R12 bottom corner
      do_req(32'h00C0_0000);   // R6 invalid bit with nonzero frame
    end
    drain();

    // R10: new base, same address, new result
    tbase = 32'h0008_0000;
    do_req(32'h0040_3ABC);
    drain();

    // R10: base changed in the middle of a walk is not used
    lat = 3;
    tbase = 32'h0001_0000;
    do_req(32'h0040_3ABC);
    tbase = 32'h0008_0000;
    drain();
    tbase = 32'h0001_0000;

    // R11: pulse while busy is ignored
    do_req(32'h0040_3ABC);
    req_valid = 1'b1; req_vaddr = 32'hFFFF_FFFF;
    @(negedge clk);
    req_valid = 1'b0;
    drain();
    repeat (5) @(negedge clk);
    chk(!busy && sb.size() == 0, "R11 no extra walk", {31'b0, busy}, 32'h0);
    finish_up();
  end
endmodule